// File: doc/BRIEF.md
# Window Watchdog with Frame-Synchronised Restart

This block supervises software with a windowed watchdog. Software programs one 8-bit control register through a serial-bus write port. The register holds an enable bit that can only be set, a two-bit period select, and a restart request bit. Each watchdog period has two equal halves. In the first half, the closed window, a restart is treated as a fault. In the second half, the open window, a restart reloads the count. If the count reaches the end of the period, or a restart lands in the closed window, the block raises a one-cycle system reset request.

The time base comes from an external `tick` strobe. One unit period (the shortest setting) lasts `TICKS_UNIT` ticks, and the longer settings are 2, 4 and 8 times that length. `TICKS_UNIT` must be at least 2. A restart request is latched when the register is written. It is applied only when the serial frame closes, which is the rising edge of the active-low select `cs_n`.

Two low-power inputs change the behaviour. While `stop_i` is high the count is frozen, and it restarts from zero when stop ends. While `sleep_i` is high the watchdog is switched off and the enable bit is cleared.

The write port is a valid-only strobe with no back-pressure. Every cycle with `wr_valid` high is accepted, and no ready signal exists.

Top module: `window_watchdog`

## Requirements
- R1: After reset, `rd_data` reads 0x00 and `sys_rst` is low.
- R2: Bit 7 is the enable. Writing 1 sets it. Writing 0 leaves it set. Only reset or sleep clears it.
- R3: With no restart, the first `sys_rst` pulse follows the tick count chosen by bits 6:5: 00 gives 8*TICKS_UNIT, 01 gives 4*TICKS_UNIT, 10 gives 2*TICKS_UNIT and 11 gives TICKS_UNIT. The count is measured from the enabling write.
- R4: A restart applied while the count is at or above half the period (open window) reloads the count to zero and raises no pulse.
- R5: A restart applied while the count is below half the period (closed window) raises a `sys_rst` pulse.
- R6: Writing 1 to bit 0 has no effect while `cs_n` stays low. The restart is applied in the cycle after `cs_n` is first sampled high.
- R7: Writing 0 to bit 0 requests nothing. Bits 4:0 always read as 0, and bits 7:5 read back their stored values.
- R8: `sys_rst` is high for exactly one cycle. After a pulse the count restarts from zero, so the next timeout takes a full period.
- R9: While `stop_i` is high the count does not advance. When `stop_i` falls the count is cleared, giving a full period after wake-up.
- R10: While `sleep_i` is high the enable is cleared, the count is cleared, and writes to the enable are ignored. After sleep ends, software must set the enable again.
- R11: While the enable is 0, `sys_rst` never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| wr_valid | input | 1 | Register write strobe from the serial bus |
| wr_data | input | 8 | Register write value |
| cs_n | input | 1 | Active-low serial select; its rising edge closes a frame |
| stop_i | input | 1 | Stop mode: freeze the count |
| sleep_i | input | 1 | Sleep mode: disable the watchdog |
| rd_data | output | 8 | Register read value |
| sys_rst | output | 1 | One-cycle system reset request |

## Verification
The assertions check these properties on every cycle:
- the reset request is never two cycles long;
- the enable never drops except through sleep;
- sleep always clears the enable;
- the unused and write-only bits read 0;
- no pulse is raised while disabled;
- the count holds still during stop.

Other behaviours can only be shown by the bench's scenarios, because they depend on a sequence of stimulus:
- the exact timeout for each period code;
- whether a restart lands in the open or closed half;
- deferring a restart to the end of the frame;
- clearing the count on wake-up;
- re-arming after sleep.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  // Period select codes; a larger code gives a shorter period.
  typedef enum logic [1:0] {
    PER_X8 = 2'b00,
    PER_X4 = 2'b01,
    PER_X2 = 2'b10,
    PER_X1 = 2'b11
  } per_sel_e;

  // Control register field positions.
  localparam int unsigned EN_BIT   = 7;
  localparam int unsigned PER_HI   = 6;
  localparam int unsigned PER_LO   = 5;
  localparam int unsigned KICK_BIT = 0;
  localparam int unsigned NUM_PER  = 4;

  typedef struct packed {
    logic     en;
    per_sel_e per;
  } wdw_cfg_t;

endpackage

// File: rtl/wdw_ctrl_reg.sv
module wdw_ctrl_reg
  import wdw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       cs_n,
  input  logic       sleep_i,
  output wdw_cfg_t   cfg,
  output logic [7:0] rd_data,
  output logic       restart_apply
);

  logic     cs_q;
  logic     kick_pend;
  wdw_cfg_t cfg_q;

  // A restart is applied when the frame closes (select rises).
  assign restart_apply = kick_pend & cs_n & ~cs_q & ~sleep_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '{en: 1'b0, per: PER_X8};
      kick_pend <= 1'b0;
      cs_q      <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (sleep_i) begin
        cfg_q.en  <= 1'b0;
        kick_pend <= 1'b0;
      end else begin
        if (restart_apply) kick_pend <= 1'b0;
        if (wr_valid) begin
          // The enable can be set but never cleared by a write.
          cfg_q.en  <= cfg_q.en | wr_data[EN_BIT];
          cfg_q.per <= per_sel_e'(wr_data[PER_HI:PER_LO]);
          if (wr_data[KICK_BIT]) kick_pend <= 1'b1;
        end
      end
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    rd_data                 = '0;
    rd_data[EN_BIT]         = cfg_q.en;
    rd_data[PER_HI:PER_LO]  = cfg_q.per;
  end

endmodule

// File: rtl/wdw_counter.sv
module wdw_counter
  import wdw_pkg::*;
#(
  parameter int unsigned TICKS_UNIT = 10,
  localparam int unsigned CW        = $clog2(8 * TICKS_UNIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  wdw_cfg_t      cfg,
  input  logic          restart,
  input  logic          stop_i,
  input  logic          sleep_i,
  output logic [CW-1:0] cnt,
  output logic          fire
);

  logic [CW-1:0] lim_tab [NUM_PER];
  logic [CW-1:0] lim;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt_q;
  logic          closed;
  logic          stop_q;
  logic          fire_q;

  // Period length for each select code: the unit shifted by 3 minus the code.
  for (genvar g = 0; g < NUM_PER; g++) begin : g_lim
    assign lim_tab[g] = CW'(TICKS_UNIT << (NUM_PER - 1 - g));
  end

  assign lim    = lim_tab[cfg.per];
  assign half   = lim >> 1;
  assign closed = cnt_q < half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
      stop_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      stop_q <= stop_i;
      if (sleep_i || !cfg.en) begin
        cnt_q <= '0;
      end else if (restart) begin
        // Closed-window restart is a fault; either way the count reloads.
        cnt_q  <= '0;
        fire_q <= closed;
      end else if (stop_q && !stop_i) begin
        cnt_q <= '0;
      end else if (!stop_i && tick) begin
        if (cnt_q >= lim - 1'b1) begin
          cnt_q  <= '0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt  = cnt_q;
  assign fire = fire_q;

endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdw_pkg::*;
#(
  parameter int unsigned TICKS_UNIT = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       cs_n,
  input  logic       stop_i,
  input  logic       sleep_i,
  output logic [7:0] rd_data,
  output logic       sys_rst
);

  localparam int unsigned CW = $clog2(8 * TICKS_UNIT + 1);

  wdw_cfg_t      cfg;
  logic          restart_apply;
  logic [CW-1:0] cnt_q;

  wdw_ctrl_reg u_reg (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_data       (wr_data),
    .cs_n          (cs_n),
    .sleep_i       (sleep_i),
    .cfg           (cfg),
    .rd_data       (rd_data),
    .restart_apply (restart_apply)
  );

  wdw_counter #(.TICKS_UNIT(TICKS_UNIT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cfg     (cfg),
    .restart (restart_apply),
    .stop_i  (stop_i),
    .sleep_i (sleep_i),
    .cnt     (cnt_q),
    .fire    (sys_rst)
  );

endmodule

// File: rtl/window_watchdog_chk.sv
module window_watchdog_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stop_i,
  input logic          sleep_i,
  input logic [7:0]    rd_data,
  input logic          sys_rst,
  input logic          rs_apply,
  input logic [CW-1:0] cnt
);

  // R8: the reset request lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> !sys_rst);

  // R2: the enable stays set unless sleep clears it
  a_r2_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[7] && !sleep_i) |=> rd_data[7]);

  // R10: sleep clears the enable
  a_r10_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> !rd_data[7]);

  // R7: the write-only and unused bits read 0
  a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[4:0] == 5'd0);

  // R11: no pulse while disabled
  a_r11_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[7] |=> !sys_rst);

  // R9: the count holds during stop
  a_r9_stop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !sleep_i && !rs_apply) |=> $stable(cnt));

endmodule

bind window_watchdog window_watchdog_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .stop_i   (stop_i),
  .sleep_i  (sleep_i),
  .rd_data  (rd_data),
  .sys_rst  (sys_rst),
  .rs_apply (restart_apply),
  .cnt      (cnt_q)
);

// File: tb/window_watchdog_test.sv
module window_watchdog_test;

  localparam int unsigned UNIT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cs_n = 1'b1;
  logic       stop_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic [7:0] rd_data;
  logic       sys_rst;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  window_watchdog #(.TICKS_UNIT(UNIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_valid(wr_valid),
    .wr_data(wr_data), .cs_n(cs_n), .stop_i(stop_i), .sleep_i(sleep_i),
    .rd_data(rd_data), .sys_rst(sys_rst)
  );

  // Period table: select code, expected ticks to timeout (R3).
  localparam logic [1:0]  V_SEL [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int unsigned V_EXP [4] = '{8 * UNIT, 4 * UNIT, 2 * UNIT, UNIT};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    tick = 0; wr_valid = 0; cs_n = 1; stop_i = 0; sleep_i = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic frame_end();
    @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // Ticks until the first pulse, up to lim_max; 0 if none seen.
  task automatic ticks_to_pulse(input int lim_max, output int first);
    first = 0;
    for (int k = 1; k <= lim_max; k++) begin
      pulse_tick();
      if (sys_rst && first == 0) first = k;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int first;
    bit seen;

    // R1: reset state
    do_reset();
    @(negedge clk);
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(sys_rst == 1'b0, "R1 sys_rst", sys_rst, 0);

    // R3: table walk over period codes
    for (int v = 0; v < 4; v++) begin
      do_reset();
      wr({1'b1, V_SEL[v], 5'b0});
      frame_end();
      ticks_to_pulse(V_EXP[v] + 2, first);
      check(first == V_EXP[v], "R3 timeout ticks", first, V_EXP[v]);
    end

    // R11: never enabled -> no pulse
    do_reset();
    ticks_to_pulse(8 * UNIT + 4, first);
    check(first == 0, "R11 disabled pulse", first, 0);

    // R2 / R7: enable sticky, readback
    do_reset();
    wr(8'hE0); frame_end();
    wr(8'h60); frame_end();
    check(rd_data == 8'hE0, "R2 enable sticky", rd_data, 8'hE0);
    wr(8'hA1);
    check(rd_data == 8'hA0, "R7 restart bit reads 0", rd_data, 8'hA0);
    frame_end();
    do_reset();
    @(negedge clk);
    check(rd_data == 8'h00, "R2 reset clears enable", rd_data, 0);

    // R4 / R8: open-window restart reloads
    do_reset();
    wr(8'hE0); frame_end();
    repeat (3) pulse_tick();
    wr(8'hE1); frame_end();
    check(sys_rst == 1'b0, "R4 open restart no pulse", sys_rst, 0);
    ticks_to_pulse(UNIT + 1, first);
    check(first == UNIT, "R4 reload full period", first, UNIT);

    // R5 / R6 / R8: closed-window restart deferred to frame end
    do_reset();
    wr(8'hE0); frame_end();
    pulse_tick();
    wr(8'hE1);
    seen = 0;
    repeat (3) begin
      @(negedge clk);
      if (sys_rst) seen = 1;
    end
    check(seen == 0, "R6 no effect before frame end", seen, 0);
    frame_end();
    check(sys_rst == 1'b1, "R5 closed restart pulse", sys_rst, 1);
    @(negedge clk);
    check(sys_rst == 1'b0, "R8 pulse one cycle", sys_rst, 0);
    ticks_to_pulse(UNIT + 1, first);
    check(first == UNIT, "R8 count from zero after pulse", first, UNIT);

    // R7: writing 0 to restart bit does not reload
    do_reset();
    wr(8'hE0); frame_end();
    repeat (3) pulse_tick();
    wr(8'hE0); frame_end();
    check(sys_rst == 1'b0, "R7 zero write no pulse", sys_rst, 0);
    ticks_to_pulse(2, first);
    check(first == 1, "R7 zero write no reload", first, 1);

    // R9: stop freezes, wake clears
    do_reset();
    wr(8'hE0); frame_end();
    repeat (3) pulse_tick();
    @(negedge clk); stop_i = 1'b1;
    ticks_to_pulse(5, first);
    check(first == 0, "R9 frozen in stop", first, 0);
    @(negedge clk); stop_i = 1'b0;
    ticks_to_pulse(UNIT + 1, first);
    check(first == UNIT, "R9 wake gives full period", first, UNIT);

    // R10: sleep clears enable and count; re-arm after wake
    do_reset();
    wr(8'hE0); frame_end();
    pulse_tick(); pulse_tick();
    @(negedge clk); sleep_i = 1'b1;
    wr(8'hE0);
    @(negedge clk);
    check(rd_data[7] == 1'b0, "R10 sleep clears enable", rd_data[7], 0);
    cs_n = 1'b1;
    @(negedge clk); sleep_i = 1'b0;
    @(negedge clk);
    check(rd_data[7] == 1'b0, "R10 enable stays off after wake", rd_data[7], 0);
    ticks_to_pulse(2 * UNIT, first);
    check(first == 0, "R11 no pulse after sleep", first, 0);
    wr(8'hE0); frame_end();
    ticks_to_pulse(UNIT + 1, first);
    check(first == UNIT, "R10 re-armed full period", first, UNIT);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule